// File: doc/BRIEF.md
# SPI Command and Status Port

This block is a 16-bit SPI slave that sits between a host controller and the control logic of a supervisor chip. Each frame the host sends carries three fields: a mode request, a bank selector and a data payload. When the frame ends cleanly, the payload is written into the selected configuration bank and the mode request is passed on to the mode controller. One mode code is reserved as a pure read. That code writes nothing and requests no mode, and when it addresses the failure bank it clears the latched failure flags.

The word shifted out during a frame always answers the frame before it. At the end of each good frame the block captures three items into a response register: the operating mode reported by the mode controller, the bank selector of that frame, and the contents of that bank before any write or clear from the frame takes effect. The next frame then shifts this word out.

Chip select, clock and data are resynchronised to the system clock. Edges are detected after two flops, so the SPI clock must run well below the system clock. A frame counts only if exactly 16 rising clock edges fall inside one chip-select window. Any other frame is dropped and latches an SPI-failure flag.

Top module: `spi_cmd_if`

## Requirements
- R1: After reset, every configuration bank and every failure flag is zero, `sdo_en_o` and `mode_req_valid_o` are low, and the first frame after reset shifts out an all-zero word.
- R2: `sdo_en_o` is high while chip select is low and goes low after chip select rises, so the external data-out buffer is high-impedance between frames.
- R3: A frame word is split as bits [15:13] mode code, [12:10] bank select and [9:0] data, received MSB first and sampled on rising SCLK edges. In a 16-bit frame whose mode code is not 3'b111, the data is written into the selected bank (bank b appears on `cfg_o[10*b+9:10*b]`) once chip select rises, and at no other time.
- R4: Each 16-bit frame whose mode code is not 3'b111 raises `mode_req_valid_o` for exactly one clock, with `mode_req_o` carrying that code. This holds even when the bank write itself is ignored.
- R5: A 16-bit frame with mode code 3'b111 is a read-only command. It writes no bank and raises no mode request.
- R6: A frame with any other number of rising SCLK edges (including 0, 15 and 17) is discarded: it causes no write, no mode request and no change to the response word. It sets failure flag bit 0.
- R7: The word shifted out MSB first on `sdo_o`, changing after falling SCLK edges, is {mode_sts_i, bank select, bank contents before the update} captured at the end of the previous 16-bit frame. Bits beyond the 16th are zero.
- R8: Bank 3'b001 is the failure bank. Its bits [9:1] latch `fail_evt_i[8:0]` pulses and bit 0 is the SPI-failure flag. The flags stay set until a read-only frame to bank 3'b001 clears all of them, after they have been captured into the response.
- R9: A write frame to bank 3'b001 does not change the failure flags or any `cfg_o` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csn_i | input | 1 | SPI chip select, active low |
| sck_i | input | 1 | SPI clock from host, idle low |
| sdi_i | input | 1 | Serial data from host |
| sdo_o | output | 1 | Serial data to host |
| sdo_en_o | output | 1 | Output enable for the data-out buffer |
| mode_sts_i | input | 3 | Current operating mode from the mode controller |
| fail_evt_i | input | 9 | Failure event pulses, one per source |
| mode_req_o | output | 3 | Requested mode code |
| mode_req_valid_o | output | 1 | One-clock strobe for a mode request |
| cfg_o | output | 80 | Eight 10-bit configuration banks, bank 1 fixed at zero |
| fail_flags_o | output | 10 | Latched failure flags |

## Verification
The bench uses the default field widths (3/3/10) and two synchroniser stages, and runs the SPI clock at eight system clocks per bit. At that rate the detected edges land well inside each SCLK phase, and every `sdo_o` bit can be compared against the model's pipelined response. The 3-bit selector lets the bench reach both end banks, 0 and 7, as well as the failure bank. Frames of 0, 15 and 17 bits are used to show that the bad-frame path leaves the response word intact.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int MODE_W    = 3;
  localparam int SEL_W     = 3;
  localparam int DATA_W    = 10;
  localparam int FRAME_W   = MODE_W + SEL_W + DATA_W;
  localparam int NBANK     = 2 ** SEL_W;
  localparam int EVT_W     = DATA_W - 1;
  localparam logic [MODE_W-1:0] RO_CODE   = '1;
  localparam logic [SEL_W-1:0]  FAIL_BANK = SEL_W'(1);

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [SEL_W-1:0]  sel;
    logic [DATA_W-1:0] data;
  } cmd_t;
endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csn_i,
  input  logic sck_i,
  input  logic sdi_i,
  output logic cs_low_o,
  output logic cs_fall_o,
  output logic cs_rise_o,
  output logic sck_rise_o,
  output logic sck_fall_o,
  output logic sdi_o
);
  // bit 2 csn, bit 1 sck, bit 0 sdi
  logic [STAGES:0][2:0] pipe_q;
  logic [2:0] cur, prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= {(STAGES+1){3'b100}};
    else         pipe_q <= {pipe_q[STAGES-1:0], {csn_i, sck_i, sdi_i}};
  end

  assign cur        = pipe_q[STAGES-1];
  assign prev       = pipe_q[STAGES];
  assign cs_low_o   = !cur[2];
  assign cs_fall_o  = prev[2] && !cur[2];
  assign cs_rise_o  = !prev[2] && cur[2];
  assign sck_rise_o = !prev[1] && cur[1];
  assign sck_fall_o = prev[1] && !cur[1];
  assign sdi_o      = cur[0];
endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift #(
  parameter int FRAME_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_low_i,
  input  logic               cs_fall_i,
  input  logic               cs_rise_i,
  input  logic               sck_rise_i,
  input  logic               sck_fall_i,
  input  logic               sdi_i,
  input  logic [FRAME_W-1:0] resp_i,
  output logic [FRAME_W-1:0] rx_o,
  output logic               frame_ok_o,
  output logic               frame_bad_o,
  output logic               sdo_o,
  output logic               sdo_en_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] rx_q, tx_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               en_q, ok_q, bad_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q  <= '0;
      tx_q  <= '0;
      cnt_q <= '0;
      en_q  <= 1'b0;
      ok_q  <= 1'b0;
      bad_q <= 1'b0;
    end else begin
      ok_q  <= cs_rise_i && (cnt_q == CNT_FULL);
      bad_q <= cs_rise_i && (cnt_q != CNT_FULL);
      if (cs_fall_i) begin
        cnt_q <= '0;
        tx_q  <= resp_i;
        en_q  <= 1'b1;
      end else if (cs_low_i) begin
        if (sck_rise_i) begin
          rx_q <= {rx_q[FRAME_W-2:0], sdi_i};
          if (cnt_q <= CNT_FULL) cnt_q <= cnt_q + 1'b1;  // saturate one past full
        end
        if (sck_fall_i) tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
      end
      if (cs_rise_i) en_q <= 1'b0;
    end
  end

  assign rx_o        = rx_q;
  assign frame_ok_o  = ok_q;
  assign frame_bad_o = bad_q;
  assign sdo_o       = tx_q[FRAME_W-1];
  assign sdo_en_o    = en_q;

  a_r2_release_on_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_rise_i |=> !sdo_en_o);
  a_r7_load_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (tx_q == $past(resp_i)));
  a_r6_single_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_bad_o |-> !frame_ok_o);
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    frame_ok_i,
  input  logic                    frame_bad_i,
  input  cmd_t                    cmd_i,
  input  logic [MODE_W-1:0]       mode_sts_i,
  input  logic [EVT_W-1:0]        fail_evt_i,
  output logic [FRAME_W-1:0]      resp_o,
  output logic [MODE_W-1:0]       mode_req_o,
  output logic                    mode_req_valid_o,
  output logic [NBANK*DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0]       flags_o
);
  logic [DATA_W-1:0]  cfg_q [NBANK];
  logic [DATA_W-1:0]  flags_q, rd_data;
  logic [FRAME_W-1:0] resp_q;
  logic [MODE_W-1:0]  req_q;
  logic               req_vld_q;
  logic               ro_cmd, wr_en, ro_clr;

  assign ro_cmd  = (cmd_i.mode == RO_CODE);
  assign wr_en   = frame_ok_i && !ro_cmd;
  assign ro_clr  = frame_ok_i && ro_cmd && (cmd_i.sel == FAIL_BANK);
  assign rd_data = (cmd_i.sel == FAIL_BANK) ? flags_q : cfg_q[cmd_i.sel];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    if (b == int'(FAIL_BANK)) begin : g_status
      assign cfg_q[b] = '0;
    end else begin : g_cfg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                   cfg_q[b] <= '0;
        else if (wr_en && (cmd_i.sel == SEL_W'(b)))    cfg_q[b] <= cmd_i.data;
      end
      a_r3_write_only_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(cfg_q[b]) |-> $past(wr_en && (cmd_i.sel == SEL_W'(b))));
    end
    assign cfg_o[b*DATA_W +: DATA_W] = cfg_q[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q   <= '0;
      resp_q    <= '0;
      req_q     <= '0;
      req_vld_q <= 1'b0;
    end else begin
      // new events win over a clear in the same cycle
      flags_q   <= (ro_clr ? '0 : flags_q) | {fail_evt_i, frame_bad_i};
      req_vld_q <= wr_en;
      if (wr_en)      req_q  <= cmd_i.mode;
      if (frame_ok_i) resp_q <= {mode_sts_i, cmd_i.sel, rd_data};
    end
  end

  assign resp_o           = resp_q;
  assign mode_req_o       = req_q;
  assign mode_req_valid_o = req_vld_q;
  assign flags_o          = flags_q;

  a_r4_req_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_req_valid_o |=> !mode_req_valid_o);
  a_r5_no_ro_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_req_valid_o |-> (mode_req_o != RO_CODE));
  a_r6_bad_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_bad_i |=> flags_q[0]);
  a_r8_clear_only_by_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(flags_q) & ~flags_q)) |-> $past(ro_clr));
endmodule

// File: rtl/spi_cmd_if.sv
module spi_cmd_if
  import spi_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    csn_i,
  input  logic                    sck_i,
  input  logic                    sdi_i,
  output logic                    sdo_o,
  output logic                    sdo_en_o,
  input  logic [MODE_W-1:0]       mode_sts_i,
  input  logic [EVT_W-1:0]        fail_evt_i,
  output logic [MODE_W-1:0]       mode_req_o,
  output logic                    mode_req_valid_o,
  output logic [NBANK*DATA_W-1:0] cfg_o,
  output logic [DATA_W-1:0]       fail_flags_o
);
  logic cs_low, cs_fall, cs_rise, sck_rise, sck_fall, sdi_s;
  logic frame_ok, frame_bad;
  logic [FRAME_W-1:0] rx_word, resp_word;

  spi_cmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .csn_i, .sck_i, .sdi_i,
    .cs_low_o(cs_low), .cs_fall_o(cs_fall), .cs_rise_o(cs_rise),
    .sck_rise_o(sck_rise), .sck_fall_o(sck_fall), .sdi_o(sdi_s)
  );

  spi_cmd_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i, .rst_ni,
    .cs_low_i(cs_low), .cs_fall_i(cs_fall), .cs_rise_i(cs_rise),
    .sck_rise_i(sck_rise), .sck_fall_i(sck_fall), .sdi_i(sdi_s),
    .resp_i(resp_word), .rx_o(rx_word),
    .frame_ok_o(frame_ok), .frame_bad_o(frame_bad),
    .sdo_o, .sdo_en_o
  );

  spi_cmd_regs u_regs (
    .clk_i, .rst_ni,
    .frame_ok_i(frame_ok), .frame_bad_i(frame_bad),
    .cmd_i(cmd_t'(rx_word)),
    .mode_sts_i, .fail_evt_i,
    .resp_o(resp_word),
    .mode_req_o, .mode_req_valid_o,
    .cfg_o, .flags_o(fail_flags_o)
  );
endmodule

// File: tb/spi_cmd_if_tb.sv
module spi_cmd_if_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic csn = 1'b1, sck = 1'b0, sdi = 1'b0;
  logic [2:0] sts = 3'd0;
  logic [8:0] evt = '0;
  logic sdo, sdo_en, req_vld;
  logic [2:0] req;
  logic [79:0] cfg;
  logic [9:0] flags;

  int vectors = 0, miscompares = 0;
  int req_cnt = 0;
  logic [2:0] last_req = '0;

  logic [9:0]  m_cfg [8];
  logic [9:0]  m_flags = '0;
  logic [15:0] m_resp = '0;
  int          m_req_cnt = 0;
  logic [2:0]  m_last_req = '0;

  always #2.5 clk = ~clk;

  spi_cmd_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .csn_i(csn), .sck_i(sck), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_en_o(sdo_en), .mode_sts_i(sts), .fail_evt_i(evt),
    .mode_req_o(req), .mode_req_valid_o(req_vld), .cfg_o(cfg), .fail_flags_o(flags)
  );

  always @(negedge clk) if (req_vld) begin
    req_cnt++;
    last_req = req;
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [79:0] m_cfg_flat();
    logic [79:0] f;
    for (int b = 0; b < 8; b++) f[b*10 +: 10] = m_cfg[b];
    return f;
  endfunction

  task automatic check_state();
    chk(cfg === m_cfg_flat(), "R3/R9 cfg", cfg, m_cfg_flat());
    chk(flags === m_flags, "R6/R8 flags", 80'(flags), 80'(m_flags));
    chk(req_cnt == m_req_cnt, "R4/R5 req count", 80'(req_cnt), 80'(m_req_cnt));
    chk(last_req === m_last_req, "R4 req code", 80'(last_req), 80'(m_last_req));
    chk(sdo_en === 1'b0, "R2 sdo_en idle", 80'(sdo_en), 80'(0));
  endtask

  task automatic frame(input logic [15:0] w, input int nbits);
    logic [15:0] exp_tx;
    logic        exp_bit;
    exp_tx = m_resp;
    csn = 1'b0;
    wait_n(4);
    chk(sdo_en === 1'b1, "R2 sdo_en active", 80'(sdo_en), 80'(1));
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? w[15-i] : 1'b0;
      wait_n(4);
      exp_bit = (i < 16) ? exp_tx[15-i] : 1'b0;
      chk(sdo === exp_bit, "R7 sdo bit", 80'(sdo), 80'(exp_bit));
      sck = 1'b1;
      wait_n(4);
      sck = 1'b0;
    end
    wait_n(4);
    csn = 1'b1;
    wait_n(10);
    if (nbits == 16) begin
      logic [2:0] md, sl;
      logic [9:0] old;
      md  = w[15:13];
      sl  = w[12:10];
      old = (sl == 3'd1) ? m_flags : m_cfg[sl];
      m_resp = {sts, sl, old};
      if (md == 3'b111) begin
        if (sl == 3'd1) m_flags = '0;
      end else begin
        m_req_cnt++;
        m_last_req = md;
        if (sl != 3'd1) m_cfg[sl] = w[9:0];
      end
    end else begin
      m_flags[0] = 1'b1;
    end
    check_state();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    for (int b = 0; b < 8; b++) m_cfg[b] = '0;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(4);
    // R1 reset state
    chk(cfg === '0, "R1 cfg reset", cfg, '0);
    chk(flags === '0, "R1 flags reset", 80'(flags), 80'(0));
    chk(sdo_en === 1'b0, "R1 sdo_en reset", 80'(sdo_en), 80'(0));
    chk(req_vld === 1'b0, "R1 req_vld reset", 80'(req_vld), 80'(0));

    sts = 3'd2;
    frame({3'b010, 3'd5, 10'h2A5}, 16);      // R1 zero response, R3 write, R4 request
    sts = 3'd3;
    frame({3'b011, 3'd6, 10'h155}, 16);
    sts = 3'd4;
    frame({3'b111, 3'd5, 10'h3FF}, 16);      // R5 read-only, no write
    frame({3'b001, 3'd1, 10'h3FF}, 16);      // R9 failure bank write ignored
    sts = 3'd1;
    frame({3'b010, 3'd0, 10'h0F0}, 15);      // R6 short
    frame({3'b010, 3'd0, 10'h0F0}, 17);      // R6 long
    frame(16'h0000, 0);                      // R6 empty
    // R8 event latching
    evt = 9'h105;
    wait_n(1);
    evt = '0;
    m_flags = m_flags | {9'h105, 1'b0};
    wait_n(2);
    chk(flags === m_flags, "R8 event latch", 80'(flags), 80'(m_flags));
    frame({3'b111, 3'd1, 10'h000}, 16);      // R8 read clears flags
    frame({3'b111, 3'd2, 10'h000}, 16);      // R7 shows old flags
    frame({3'b000, 3'd0, 10'h3C3}, 16);      // R3 lowest bank
    sts = 3'd6;
    frame({3'b101, 3'd7, 10'h1E1}, 16);      // R3 highest bank
    frame({3'b111, 3'd7, 10'h000}, 16);      // R7 readback of bank 7
    frame({3'b111, 3'd0, 10'h000}, 16);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule